// File: doc/BRIEF.md
# Graded-Stage Carry-Select Adder

This block adds two unsigned operands and an incoming carry, producing a full-width sum and a carry-out. It is purely combinational and has no clock or reset. The operand width is split into consecutive stages. Each stage finds its carry-out by rippling from bit to bit.

The lowest stage adds its slice directly with the external carry-in. Every higher stage works out its slice twice at the same time, once assuming an incoming carry of 0 and once assuming 1. When the real carry arrives from the stage below, the stage picks the matching slice and carry-out.

Stage widths come from a parameter list and may grow from one stage to the next. Because of this growth, the longer internal ripple of an upper stage finishes while the selecting carry is still travelling up the chain of multiplexers. The total delay therefore stays close to the first stage's ripple plus one multiplexer per stage. A layout whose widths do not add up to the operand width is rejected at elaboration, and so is a layout that grows faster than the allowed step.

Top module: `vcsel_adder`

## Requirements
- R1: `sum` equals the low WIDTH bits of `a + b + cin`, for every combination of inputs.
- R2: `cout` equals bit WIDTH of the (WIDTH+1)-bit value `a + b + cin`. In particular, `cout` is 1 whenever both operands have their top bit set.
- R3: The carry leaving each stage equals the carry out of the exact sum of all operand bits below that stage's upper edge plus `cin`. A carry produced in any stage therefore reaches every later stage.
- R4: The lowest stage takes `cin` directly. With `a = b = 0`, `sum` equals `cin` and `cout` is 0.
- R5: When every bit position propagates (`a ^ b` all ones), `cout` equals `cin`. With `a` all ones, `b = 0` and `cin = 1`, the result is `sum = 0` and `cout = 1`.
- R6: The entries of the stage-width list must add up to exactly WIDTH. No entry may exceed the entry before it by more than MAX_GROW bits. Any other list stops elaboration. The default list 4,5,6,7,10 tiles bits 0..31 with stage edges after bits 3, 8, 14 and 21.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | WIDTH | First operand |
| b | input | WIDTH | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | WIDTH | Low WIDTH bits of the total |
| cout | output | 1 | Carry out of the top stage |

## Verification
The checker compares the full result against an arithmetic add whenever the inputs change. It also checks the carry at every stage edge against a partial add, and covers the all-propagate and zero-operand cases. The bench's scenarios show what the assertions cannot pick out as named cases: vectors chosen so that a carry crosses each particular stage edge, a carry that travels across every edge at once, and the result for the default width list as a whole.

// File: rtl/vcsel_pkg.sv
package vcsel_pkg;
  // Candidate carry-outs of one select stage, one per assumed carry-in.
  typedef struct packed {
    logic carryIfZero;
    logic carryIfOne;
  } carryPair_t;
endpackage

// File: rtl/csa_ripple.sv
module csa_ripple #(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);
  logic [W:0] rc;
  assign rc[0] = cin;

  for (genvar k = 0; k < W; k++) begin : g_bit
    assign sum[k]  = a[k] ^ b[k] ^ rc[k];
    assign rc[k+1] = (a[k] & b[k]) | (rc[k] & (a[k] ^ b[k]));
  end

  assign cout = rc[W];
endmodule

// File: rtl/csa_select.sv
module csa_select
  import vcsel_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [W-1:0] sumIfZero,
  input  logic [W-1:0] sumIfOne,
  input  carryPair_t   pair,
  input  logic         sel,
  output logic [W-1:0] sum,
  output logic         cout
);
  assign sum  = sel ? sumIfOne : sumIfZero;
  assign cout = sel ? pair.carryIfOne : pair.carryIfZero;
endmodule

// File: rtl/csa_stage.sv
module csa_stage
  import vcsel_pkg::*;
#(
  parameter int W        = 4,
  parameter bit SELECTED = 1'b1
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);
  if (!SELECTED) begin : g_direct
    csa_ripple #(.W(W)) u_rip (
      .a(a), .b(b), .cin(cin), .sum(sum), .cout(cout)
    );
  end else begin : g_dual
    logic [W-1:0] sumZero, sumOne;
    carryPair_t   pair;

    csa_ripple #(.W(W)) u_ripZero (
      .a(a), .b(b), .cin(1'b0), .sum(sumZero), .cout(pair.carryIfZero)
    );
    csa_ripple #(.W(W)) u_ripOne (
      .a(a), .b(b), .cin(1'b1), .sum(sumOne), .cout(pair.carryIfOne)
    );
    csa_select #(.W(W)) u_sel (
      .sumIfZero(sumZero), .sumIfOne(sumOne), .pair(pair),
      .sel(cin), .sum(sum), .cout(cout)
    );
  end
endmodule

// File: rtl/vcsel_adder.sv
module vcsel_adder #(
  parameter int WIDTH                = 32,
  parameter int NUM_STAGES           = 5,
  parameter int STAGE_W [NUM_STAGES] = '{4, 5, 6, 7, 10},
  parameter int MAX_GROW             = 3
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout
);
  function automatic int stageBase(int idx);
    int acc = 0;
    for (int k = 0; k < idx; k++) acc += STAGE_W[k];
    return acc;
  endfunction

  localparam int LAYOUT_BITS = stageBase(NUM_STAGES);

  // R6: layout checks at elaboration
  if (LAYOUT_BITS != WIDTH) begin : g_badSum
    $error("stage widths add to %0d, operand width is %0d", LAYOUT_BITS, WIDTH);
  end
  for (genvar g = 1; g < NUM_STAGES; g++) begin : g_growChk
    if (STAGE_W[g] - STAGE_W[g-1] > MAX_GROW) begin : g_badGrow
      $error("stage %0d grows by more than %0d bits", g, MAX_GROW);
    end
  end

  logic [NUM_STAGES:0] carryChain;
  assign carryChain[0] = cin;

  for (genvar s = 0; s < NUM_STAGES; s++) begin : g_stage
    localparam int LO = stageBase(s);
    localparam int SW = STAGE_W[s];
    csa_stage #(.W(SW), .SELECTED(s != 0)) u_stage (
      .a   (a[LO +: SW]),
      .b   (b[LO +: SW]),
      .cin (carryChain[s]),
      .sum (sum[LO +: SW]),
      .cout(carryChain[s+1])
    );
  end

  assign cout = carryChain[NUM_STAGES];
endmodule

// File: rtl/vcsel_adder_chk.sv
module vcsel_adder_chk #(
  parameter int WIDTH                = 32,
  parameter int NUM_STAGES           = 5,
  parameter int STAGE_W [NUM_STAGES] = '{4, 5, 6, 7, 10}
) (
  input logic [WIDTH-1:0]    a,
  input logic [WIDTH-1:0]    b,
  input logic                cin,
  input logic [WIDTH-1:0]    sum,
  input logic                cout,
  input logic [NUM_STAGES:0] carryChain
);
  logic [WIDTH:0] total;
  assign total = {1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin};

  always_comb begin
    AST_SUM_EXACT: assert (sum == total[WIDTH-1:0]); // R1
    AST_COUT_EXACT: assert (cout == total[WIDTH]); // R2
    AST_TOP_GENERATE: assert (!(a[WIDTH-1] && b[WIDTH-1]) || cout); // R2
    AST_ZERO_OPERANDS: assert (!(a == '0 && b == '0) || (sum == {{(WIDTH-1){1'b0}}, cin} && !cout)); // R4
    AST_FULL_PROPAGATE: assert (!(&(a ^ b)) || cout == cin); // R5
  end

  always_comb begin
    int hi;
    logic [WIDTH:0] low;
    logic [WIDTH:0] part;
    hi = 0;
    for (int i = 0; i < NUM_STAGES; i++) begin
      hi   = hi + STAGE_W[i];
      low  = ({{WIDTH{1'b0}}, 1'b1} << hi) - {{WIDTH{1'b0}}, 1'b1};
      part = ({1'b0, a} & low) + ({1'b0, b} & low) + {{WIDTH{1'b0}}, cin};
      AST_EDGE_CARRY: assert (carryChain[i+1] == part[hi]); // R3
    end
  end
endmodule

bind vcsel_adder vcsel_adder_chk #(
  .WIDTH(WIDTH), .NUM_STAGES(NUM_STAGES), .STAGE_W(STAGE_W)
) u_chk (.*);

// File: tb/vcsel_adder_tb.sv
`timescale 1ns/1ps
module vcsel_adder_tb;
  localparam int W        = 32;
  localparam int NS       = 5;
  localparam int SW [NS]  = '{4, 5, 6, 7, 10};
  localparam int WATCHDOG = 200000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk;

  logic [W-1:0] a, b, sum;
  logic         cin, cout;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  vcsel_adder #(.WIDTH(W), .NUM_STAGES(NS), .STAGE_W(SW), .MAX_GROW(3)) u_dut (
    .a(a), .b(b), .cin(cin), .sum(sum), .cout(cout)
  );

  logic [W:0] expQ[$];

  task automatic applyVec(input logic [W-1:0] va, input logic [W-1:0] vb,
                          input logic vc, input string req);
    logic [W:0] exp;
    @(posedge clk);
    a = va; b = vb; cin = vc;
    exp = {1'b0, va} + {1'b0, vb} + (vc ? 1 : 0);
    expQ.push_back(exp);
    @(negedge clk);
    exp = expQ.pop_front();
    vectors++;
    if ({cout, sum} !== exp) begin
      miscompares++;
      $display("FAIL %s: a=%h b=%h cin=%b got cout=%b sum=%h expected cout=%b sum=%h",
               req, va, vb, vc, cout, sum, exp[W], exp[W-1:0]);
    end
  endtask

  initial begin
    a = '0; b = '0; cin = 1'b0;
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    // R1: quiescent start
    applyVec('0, '0, 1'b0, "R1");
    // R4: carry-in alone
    applyVec('0, '0, 1'b1, "R4");
    // R5: all ones plus one, and full propagate with cin=0
    applyVec('1, '0, 1'b1, "R5");
    applyVec(32'hAAAA_AAAA, 32'h5555_5555, 1'b0, "R5");
    applyVec(32'hAAAA_AAAA, 32'h5555_5555, 1'b1, "R5");
    // R2: top-bit generate
    applyVec(32'h8000_0000, 32'h8000_0000, 1'b0, "R2");
    applyVec('1, '1, 1'b1, "R2");
    // R3 / R6: carry crossing each stage edge of the default layout
    begin
      int edgeBit = 0;
      for (int s = 0; s < NS - 1; s++) begin
        edgeBit += SW[s];
        applyVec((32'd1 << edgeBit) - 1, '0, 1'b1, "R3");
        applyVec(32'd1 << (edgeBit - 1), 32'd1 << (edgeBit - 1), 1'b0, "R3");
        applyVec((32'd1 << edgeBit) - 1, 32'd1, 1'b0, "R6");
      end
    end
    // R1/R2: random vectors
    for (int i = 0; i < 400; i++)
      applyVec(W'($urandom), W'($urandom), 1'($urandom), "R1");
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule